// File: doc/BRIEF.md
# PCIe Host Link Bring-Up Sequencer

This block is a hardware state machine that powers up a PCIe controller's glue logic and starts its link. A pulse on the start input runs a fixed, ordered sequence. It turns on the PHY SRAM bypass and selects the root-port device type. It loads fixed divider values into the reference-clock PLL and enables that PLL. It then polls the PLL lock input until lock arrives or a time limit runs out. After lock it releases the controller core reset. It keeps the board reset (PERST#, active low) asserted for a minimum hold time, releases it, and waits a settling time.

In root-port mode the block then starts the link. It clears the LTSSM enable, polls the PHY PLL status input under the same polling and limit scheme, and then sets the LTSSM enable and raises `done_o`. In endpoint mode the link-start phase is skipped and `done_o` rises straight after the settling time. When either poll reaches its limit, the block raises `err_o`, drives PERST# back to asserted and stops.

A stop input clears the LTSSM enable at any time. All time constants are given in microseconds, together with the clock rate in MHz, and are converted to clock cycles at elaboration. A bench can therefore shorten them.

Top module: `pcie_linkup_seq`

## Requirements
- R1: After reset every control output is 0, including `perst_n_o` (PERST# asserted), and `done_o` and `err_o` are 0.
- R2: A start pulse accepted in the idle, done or error state clears all outputs. On the following edges the block sets `sram_bypass_o`, then `dev_type_o`, then the PLL divider outputs, then `pll_en_o`, one edge apart.
- R3: The divider outputs are reference 0, feedback 0x032, post dividers 2 and 2. `pll_en_o` rises together with an output-enable value of 0xC.
- R4: PLL lock is sampled once at the end of every interval of CLK_MHZ*POLL_US cycles, counted from entry to the wait. The first sample that sees lock ends the wait, and the next edge sets `core_rel_o`.
- R5: If LIMIT_US/POLL_US consecutive lock samples fail, `err_o` rises, `perst_n_o` stays 0, and no later output of the sequence changes.
- R6: After the core reset is released, `perst_n_o` stays 0 for CLK_MHZ*HOLD_US cycles and then goes to 1.
- R7: In root-port mode (`ep_mode_i`=0), after CLK_MHZ*SETTLE_US cycles the block clears LTSSM enable and polls `phy_pll_ok_i` as in R4. On success it sets `ltssm_en_o` and `done_o` on the same edge.
- R8: If the PHY PLL poll reaches its limit, `err_o` rises and `perst_n_o` is driven back to 0 on the same edge.
- R9: In endpoint mode (`ep_mode_i`=1), `done_o` rises when the settling time ends, and `ltssm_en_o` stays 0.
- R10: `stop_i` high at an edge leaves `ltssm_en_o` at 0 after that edge, taking priority over a set. `done_o` is not affected.
- R11: `err_o` stays high until the next start. A start pulse while the sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the bring-up sequence |
| stop_i | input | 1 | Clear LTSSM enable |
| ep_mode_i | input | 1 | 1 = endpoint mode, skip link start |
| pll_lock_i | input | 1 | Reference PLL lock status |
| phy_pll_ok_i | input | 1 | PHY PLL status |
| sram_bypass_o | output | 1 | PHY SRAM bypass control |
| dev_type_o | output | 1 | Root-port device type select |
| pll_ref_div_o | output | 6 | PLL reference divider |
| pll_fb_div_o | output | 12 | PLL feedback divider |
| pll_post_a_o | output | 3 | PLL first post divider |
| pll_post_b_o | output | 3 | PLL second post divider |
| pll_en_o | output | 1 | PLL enable |
| pll_fout_en_o | output | 4 | PLL output-enable field |
| core_rel_o | output | 1 | Controller core reset release |
| perst_n_o | output | 1 | Board reset, 0 = asserted |
| ltssm_en_o | output | 1 | Link training enable |
| done_o | output | 1 | Sequence complete |
| err_o | output | 1 | Lock timeout occurred |

## Verification
A wrong state or a miscounted timer shows at the ports as a control bit that changes out of order or on the wrong edge. For example, PERST# could release before the core reset, or LTSSM enable could rise one poll interval early. Every output is compared with an independent model on every clock, so such a fault is reported within the cycle it first appears. A poll counter that is off by one shows up as a lock or PHY-status sample taken at the wrong cycle, which moves every later output transition. A timeout fault shows up as `err_o` on the wrong edge or as PERST# left released after an error.

// File: rtl/pcie_linkup_pkg.sv
package pcie_linkup_pkg;

    localparam logic [5:0]  REF_DIV_VAL  = 6'd0;
    localparam logic [11:0] FB_DIV_VAL   = 12'h032;
    localparam logic [2:0]  POST_A_VAL   = 3'd2;
    localparam logic [2:0]  POST_B_VAL   = 3'd2;
    localparam logic [3:0]  FOUT_EN_VAL  = 4'hC;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BYPASS,
        ST_DEVTYPE,
        ST_PLLDIV,
        ST_PLLEN,
        ST_LOCKWAIT,
        ST_COREREL,
        ST_PERSTHOLD,
        ST_SETTLE,
        ST_LINKOFF,
        ST_PHYWAIT,
        ST_LINKON,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        seq_state_e  st;
        logic        byp;
        logic        dtype;
        logic [5:0]  refd;
        logic [11:0] fbd;
        logic [2:0]  pda;
        logic [2:0]  pdb;
        logic        pll_en;
        logic [3:0]  fout;
        logic        core_rel;
        logic        perst_n;
        logic        ltssm;
        logic        done;
        logic        err;
    } seq_regs_t;

endpackage

// File: rtl/pcie_linkup_poller.sv
module pcie_linkup_poller #(
    parameter int unsigned POLL_CYC = 4,
    parameter int unsigned NPOLL    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic cond_i,
    output logic ok_o,
    output logic expire_o
);
    localparam int unsigned PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam int unsigned CW = (NPOLL > 1) ? $clog2(NPOLL) : 1;

    logic [PW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] polls_d, polls_q;
    logic          tick;

    assign tick     = run_i && (cnt_q == PW'(POLL_CYC - 1));
    assign ok_o     = tick && cond_i;
    assign expire_o = tick && !cond_i && (polls_q == CW'(NPOLL - 1));

    always_comb begin
        cnt_d   = cnt_q;
        polls_d = polls_q;
        if (!run_i) begin
            cnt_d   = '0;
            polls_d = '0;
        end else if (tick) begin
            cnt_d   = '0;
            polls_d = polls_q + CW'(1);
        end else begin
            cnt_d   = cnt_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            polls_q <= '0;
        end else begin
            cnt_q   <= cnt_d;
            polls_q <= polls_d;
        end
    end
endmodule

// File: rtl/pcie_linkup_delay.sv
module pcie_linkup_delay #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] len_i,
    output logic         fire_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign fire_o = run_i && (cnt_q == (len_i - W'(1)));

    always_comb begin
        if (!run_i || fire_o) cnt_d = '0;
        else                  cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pcie_linkup_seq.sv
module pcie_linkup_seq
    import pcie_linkup_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 250,
    parameter int unsigned POLL_US  = 20,
    parameter int unsigned LIMIT_US = 500000,
    parameter int unsigned HOLD_US  = 100000,
    parameter int unsigned SETTLE_US = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic        ep_mode_i,
    input  logic        pll_lock_i,
    input  logic        phy_pll_ok_i,
    output logic        sram_bypass_o,
    output logic        dev_type_o,
    output logic [5:0]  pll_ref_div_o,
    output logic [11:0] pll_fb_div_o,
    output logic [2:0]  pll_post_a_o,
    output logic [2:0]  pll_post_b_o,
    output logic        pll_en_o,
    output logic [3:0]  pll_fout_en_o,
    output logic        core_rel_o,
    output logic        perst_n_o,
    output logic        ltssm_en_o,
    output logic        done_o,
    output logic        err_o
);
    localparam int unsigned POLL_CYC   = CLK_MHZ * POLL_US;
    localparam int unsigned NPOLL      = LIMIT_US / POLL_US;
    localparam int unsigned HOLD_CYC   = CLK_MHZ * HOLD_US;
    localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int unsigned DLY_MAX    = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int unsigned DLY_W      = $clog2(DLY_MAX + 1);

    seq_regs_t r_d, r_q;

    logic             poll_run, poll_cond, poll_ok, poll_exp;
    logic             dly_run, dly_fire;
    logic [DLY_W-1:0] dly_len;

    assign poll_run  = (r_q.st == ST_LOCKWAIT) || (r_q.st == ST_PHYWAIT);
    assign poll_cond = (r_q.st == ST_LOCKWAIT) ? pll_lock_i : phy_pll_ok_i;
    assign dly_run   = (r_q.st == ST_PERSTHOLD) || (r_q.st == ST_SETTLE);
    assign dly_len   = (r_q.st == ST_PERSTHOLD) ? DLY_W'(HOLD_CYC) : DLY_W'(SETTLE_CYC);

    pcie_linkup_poller #(
        .POLL_CYC (POLL_CYC),
        .NPOLL    (NPOLL)
    ) poll_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (poll_run),
        .cond_i   (poll_cond),
        .ok_o     (poll_ok),
        .expire_o (poll_exp)
    );

    pcie_linkup_delay #(
        .W (DLY_W)
    ) dly_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (dly_run),
        .len_i  (dly_len),
        .fire_o (dly_fire)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    r_d    = '0;
                    r_d.st = ST_BYPASS;
                end
            end
            ST_BYPASS: begin
                r_d.byp = 1'b1;
                r_d.st  = ST_DEVTYPE;
            end
            ST_DEVTYPE: begin
                r_d.dtype = 1'b1;
                r_d.st    = ST_PLLDIV;
            end
            ST_PLLDIV: begin
                r_d.refd = REF_DIV_VAL;
                r_d.fbd  = FB_DIV_VAL;
                r_d.pda  = POST_A_VAL;
                r_d.pdb  = POST_B_VAL;
                r_d.st   = ST_PLLEN;
            end
            ST_PLLEN: begin
                r_d.pll_en = 1'b1;
                r_d.fout   = FOUT_EN_VAL;
                r_d.st     = ST_LOCKWAIT;
            end
            ST_LOCKWAIT: begin
                if (poll_ok) begin
                    r_d.st = ST_COREREL;
                end else if (poll_exp) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_FAIL;
                end
            end
            ST_COREREL: begin
                r_d.core_rel = 1'b1;
                r_d.st       = ST_PERSTHOLD;
            end
            ST_PERSTHOLD: begin
                if (dly_fire) begin
                    r_d.perst_n = 1'b1;
                    r_d.st      = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (dly_fire) begin
                    if (ep_mode_i) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_DONE;
                    end else begin
                        r_d.st   = ST_LINKOFF;
                    end
                end
            end
            ST_LINKOFF: begin
                r_d.ltssm = 1'b0;
                r_d.st    = ST_PHYWAIT;
            end
            ST_PHYWAIT: begin
                if (poll_ok) begin
                    r_d.st = ST_LINKON;
                end else if (poll_exp) begin
                    r_d.err     = 1'b1;
                    r_d.perst_n = 1'b0;
                    r_d.st      = ST_FAIL;
                end
            end
            ST_LINKON: begin
                r_d.ltssm = 1'b1;
                r_d.done  = 1'b1;
                r_d.st    = ST_DONE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (stop_i) r_d.ltssm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sram_bypass_o = r_q.byp;
    assign dev_type_o    = r_q.dtype;
    assign pll_ref_div_o = r_q.refd;
    assign pll_fb_div_o  = r_q.fbd;
    assign pll_post_a_o  = r_q.pda;
    assign pll_post_b_o  = r_q.pdb;
    assign pll_en_o      = r_q.pll_en;
    assign pll_fout_en_o = r_q.fout;
    assign core_rel_o    = r_q.core_rel;
    assign perst_n_o     = r_q.perst_n;
    assign ltssm_en_o    = r_q.ltssm;
    assign done_o        = r_q.done;
    assign err_o         = r_q.err;
endmodule

// File: rtl/pcie_linkup_seq_chk.sv
module pcie_linkup_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        stop_i,
    input logic        sram_bypass_o,
    input logic        dev_type_o,
    input logic [5:0]  pll_ref_div_o,
    input logic [11:0] pll_fb_div_o,
    input logic [2:0]  pll_post_a_o,
    input logic [2:0]  pll_post_b_o,
    input logic        pll_en_o,
    input logic [3:0]  pll_fout_en_o,
    input logic        core_rel_o,
    input logic        perst_n_o,
    input logic        ltssm_en_o,
    input logic        done_o,
    input logic        err_o
);
    p_core_after_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_rel_o |-> (pll_en_o && sram_bypass_o && dev_type_o));

    p_pll_values_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en_o |-> (pll_ref_div_o == 6'd0 && pll_fb_div_o == 12'h032 &&
                      pll_post_a_o == 3'd2 && pll_post_b_o == 3'd2 &&
                      pll_fout_en_o == 4'hC));

    p_err_keeps_perst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !perst_n_o);

    p_release_after_core_r6: assert property (@(posedge clk) disable iff (!rst_n)
        perst_n_o |-> core_rel_o);

    p_ltssm_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_en_o |-> (perst_n_o && done_o));

    p_no_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && done_o));

    p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !ltssm_en_o);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);
endmodule

bind pcie_linkup_seq pcie_linkup_seq_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .stop_i        (stop_i),
    .sram_bypass_o (sram_bypass_o),
    .dev_type_o    (dev_type_o),
    .pll_ref_div_o (pll_ref_div_o),
    .pll_fb_div_o  (pll_fb_div_o),
    .pll_post_a_o  (pll_post_a_o),
    .pll_post_b_o  (pll_post_b_o),
    .pll_en_o      (pll_en_o),
    .pll_fout_en_o (pll_fout_en_o),
    .core_rel_o    (core_rel_o),
    .perst_n_o     (perst_n_o),
    .ltssm_en_o    (ltssm_en_o),
    .done_o        (done_o),
    .err_o         (err_o)
);

// File: tb/pcie_linkup_seq_tb_top.sv
module pcie_linkup_seq_tb_top;
    localparam int POLL   = 4;   // CLK_MHZ=1, POLL_US=4
    localparam int NPOLL  = 5;   // LIMIT_US=20
    localparam int HOLD   = 10;
    localparam int SETTLE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, ep_mode_i = 0, pll_lock_i = 0, phy_pll_ok_i = 0;
    logic        sram_bypass_o, dev_type_o, pll_en_o, core_rel_o, perst_n_o;
    logic        ltssm_en_o, done_o, err_o;
    logic [5:0]  pll_ref_div_o;
    logic [11:0] pll_fb_div_o;
    logic [2:0]  pll_post_a_o, pll_post_b_o;
    logic [3:0]  pll_fout_en_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string scen = "R1";

    always #2 clk = ~clk;

    pcie_linkup_seq #(
        .CLK_MHZ(1), .POLL_US(4), .LIMIT_US(20), .HOLD_US(10), .SETTLE_US(3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .ep_mode_i(ep_mode_i), .pll_lock_i(pll_lock_i), .phy_pll_ok_i(phy_pll_ok_i),
        .sram_bypass_o(sram_bypass_o), .dev_type_o(dev_type_o),
        .pll_ref_div_o(pll_ref_div_o), .pll_fb_div_o(pll_fb_div_o),
        .pll_post_a_o(pll_post_a_o), .pll_post_b_o(pll_post_b_o),
        .pll_en_o(pll_en_o), .pll_fout_en_o(pll_fout_en_o),
        .core_rel_o(core_rel_o), .perst_n_o(perst_n_o), .ltssm_en_o(ltssm_en_o),
        .done_o(done_o), .err_o(err_o)
    );

    // Behavioural reference: phase names as integers, timers as integers.
    localparam int P_IDLE = 0, P_BYP = 1, P_TYP = 2, P_DIV = 3, P_EN = 4,
                   P_LOCK = 5, P_CORE = 6, P_HOLD = 7, P_SETTLE = 8,
                   P_OFF = 9, P_PHY = 10, P_ON = 11, P_DONE = 12, P_ERR = 13;
    int ph = P_IDLE, t = 0, k = 0;
    bit m_byp, m_typ, m_div, m_en, m_core, m_perst_n, m_ltssm, m_done, m_err;

    task automatic m_clear();
        m_byp = 0; m_typ = 0; m_div = 0; m_en = 0; m_core = 0;
        m_perst_n = 0; m_ltssm = 0; m_done = 0; m_err = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clear(); ph = P_IDLE; t = 0; k = 0;
        end else begin
            case (ph)
                P_IDLE, P_DONE, P_ERR: if (start_i) begin m_clear(); ph = P_BYP; end
                P_BYP:  begin m_byp = 1; ph = P_TYP; end
                P_TYP:  begin m_typ = 1; ph = P_DIV; end
                P_DIV:  begin m_div = 1; ph = P_EN; end
                P_EN:   begin m_en = 1; ph = P_LOCK; t = 0; k = 0; end
                P_LOCK: begin
                    t++;
                    if (t == POLL) begin
                        t = 0;
                        if (pll_lock_i) ph = P_CORE;
                        else begin k++; if (k == NPOLL) begin m_err = 1; ph = P_ERR; end end
                    end
                end
                P_CORE: begin m_core = 1; ph = P_HOLD; t = 0; end
                P_HOLD: begin t++; if (t == HOLD) begin m_perst_n = 1; ph = P_SETTLE; t = 0; end end
                P_SETTLE: begin
                    t++;
                    if (t == SETTLE) begin
                        if (ep_mode_i) begin m_done = 1; ph = P_DONE; end
                        else ph = P_OFF;
                    end
                end
                P_OFF:  begin m_ltssm = 0; ph = P_PHY; t = 0; k = 0; end
                P_PHY:  begin
                    t++;
                    if (t == POLL) begin
                        t = 0;
                        if (phy_pll_ok_i) ph = P_ON;
                        else begin
                            k++;
                            if (k == NPOLL) begin m_err = 1; m_perst_n = 0; ph = P_ERR; end
                        end
                    end
                end
                P_ON:   begin m_ltssm = 1; m_done = 1; ph = P_DONE; end
                default: ph = P_IDLE;
            endcase
            if (stop_i) m_ltssm = 0;
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s: got %0h expected %0h at cycle %0d", req, scen, what, got, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "sram_bypass_o", sram_bypass_o, m_byp);
            chk("R2", "dev_type_o", dev_type_o, m_typ);
            chk("R3", "pll_ref_div_o", pll_ref_div_o, 0);
            chk("R3", "pll_fb_div_o", pll_fb_div_o, m_div ? 'h32 : 0);
            chk("R3", "pll_post_a_o", pll_post_a_o, m_div ? 2 : 0);
            chk("R3", "pll_post_b_o", pll_post_b_o, m_div ? 2 : 0);
            chk("R3", "pll_en_o", pll_en_o, m_en);
            chk("R3", "pll_fout_en_o", pll_fout_en_o, m_en ? 'hC : 0);
            chk("R6", "core_rel_o", core_rel_o, m_core);
            chk("R6", "perst_n_o", perst_n_o, m_perst_n);
            chk("R7", "ltssm_en_o", ltssm_en_o, m_ltssm);
            chk("R7", "done_o", done_o, m_done);
            chk("R5", "err_o", err_o, m_err);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
    endtask

    initial begin
        idle(3);
        // R1: reset state
        chk("R1", "perst_n_o", perst_n_o, 0);
        chk("R1", "ltssm_en_o", ltssm_en_o, 0);
        chk("R1", "done_o", done_o, 0);
        chk("R1", "err_o", err_o, 0);
        chk("R1", "pll_en_o", pll_en_o, 0);
        @(negedge clk); rst_n = 1;
        idle(2);

        // R4 / R11: lock arrives mid-interval, start while busy is ignored
        scen = "R4";
        phy_pll_ok_i = 1;
        pulse_start();
        idle(10); pll_lock_i = 1;
        idle(3); pulse_start();
        idle(40);
        chk("R7", "done_o", done_o, 1);
        chk("R7", "ltssm_en_o", ltssm_en_o, 1);
        chk("R11", "perst_n_o after busy start", perst_n_o, 1);

        // R10: stop clears LTSSM, done stays
        scen = "R10";
        @(negedge clk); stop_i = 1;
        @(negedge clk); stop_i = 0;
        chk("R10", "ltssm_en_o", ltssm_en_o, 0);
        chk("R10", "done_o", done_o, 1);

        // R5: lock never arrives
        scen = "R5";
        pll_lock_i = 0;
        pulse_start();
        idle(40);
        chk("R5", "err_o", err_o, 1);
        chk("R5", "perst_n_o", perst_n_o, 0);
        chk("R5", "core_rel_o", core_rel_o, 0);
        idle(10);
        chk("R11", "err_o held", err_o, 1);

        // R8: PHY PLL status never arrives
        scen = "R8";
        pll_lock_i = 1; phy_pll_ok_i = 0;
        pulse_start();
        idle(60);
        chk("R8", "err_o", err_o, 1);
        chk("R8", "perst_n_o", perst_n_o, 0);
        chk("R8", "core_rel_o", core_rel_o, 1);

        // R9: endpoint mode skips link start
        scen = "R9";
        ep_mode_i = 1;
        pulse_start();
        idle(40);
        chk("R11", "err_o cleared by start", err_o, 0);
        chk("R9", "done_o", done_o, 1);
        chk("R9", "ltssm_en_o", ltssm_en_o, 0);
        chk("R9", "perst_n_o", perst_n_o, 1);

        // R10: stop held across link-on wins over the set
        scen = "R10";
        ep_mode_i = 0; phy_pll_ok_i = 1;
        pulse_start();
        stop_i = 1;
        idle(40);
        chk("R10", "ltssm_en_o under stop", ltssm_en_o, 0);
        chk("R10", "done_o under stop", done_o, 1);
        stop_i = 0;
        idle(5);
        chk("R10", "ltssm_en_o after stop", ltssm_en_o, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule